// File: doc/BRIEF.md
# Per-Core Local Interrupt Unit

This block holds, for every core of a cluster, a private bank of five local interrupt sources: timer, performance counter, debug channel and two software interrupts. Each bank has a mask register, a control register and one map register per source. The pending bits arrive as level inputs. A bank raises its core's interrupt line when a source is pending, unmasked and routable. It also raises one of several per-core pins, chosen by the source's map register.

Two write windows reach the banks. The local window always addresses the writing core's own bank. The other window addresses whichever bank that core last named in its selector register. A single combinational read port serves both windows. Mask bits are never written directly: a set-mask write ORs a bitmask in, and a clear-mask write removes the bitmask's bits.

Top module: `lic_local_unit`

## Requirements
- R1: Reset clears every mask, every map register and every selector. It sets each control register to the CTL_RST parameter (default 0x0F) and drives `core_irq` and `core_pin` low.
- R2: A write to address 3 ORs `wdata[4:0]` into the target bank's mask. A write to address 4 clears the mask bits that are set in `wdata[4:0]`, so writing all ones there clears the whole mask. Address 2 reads the mask back.
- R3: `core_irq[c]` is registered. One cycle after the inputs and registers are sampled, it equals the OR of the pending bits ANDed with the mask bits and the routable flags of bank c. Source bit positions are timer 0, performance counter 1, debug channel 2, software 3 and 4.
- R4: Control register (address 0) bits: bit 0 makes the timer routable, bit 1 the performance counter, bit 2 the debug channel, and bit 3 both software sources. A source that is not routable never raises `core_irq` or `core_pin`, whatever its mask and pending state.
- R5: Control bit 4 selects external-controller mode, in which all five sources are routable regardless of bits 0 to 3.
- R6: A local-window write to address 5 stores `wdata[CW-1:0]` as the writing core's selector. Later other-window writes and reads by that core reach the selected core's bank.
- R7: When a local write and an other-window write hit the same bank in the same cycle, the local write is applied first and the other-window write on top of it. Set-mask and clear-mask writes therefore compose in that order, and a plain register keeps the other-window value.
- R8: The map register of source s is at address 8+s: bit DW-1 enables the mapping, and the low PIN_W bits name a pin. `core_pin[c*NPINS+p]` is high one cycle after a serviceable source of bank c with an enabled map names pin p. A map without the enable bit drives no pin.
- R9: Writes to the pending address 1 have no effect. A selector write through the other window has no effect on any selector, and reading address 5 through the other window returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_we | input | 1 | Local-window write strobe |
| loc_core | input | CW | Core issuing the local write |
| loc_addr | input | 4 | Local-window register address |
| loc_wdata | input | DW | Local-window write data |
| oth_we | input | 1 | Other-window write strobe |
| oth_core | input | CW | Core issuing the other-window write |
| oth_addr | input | 4 | Other-window register address |
| oth_wdata | input | DW | Other-window write data |
| rd_core | input | CW | Core issuing the read |
| rd_other | input | 1 | 1 reads through the other window |
| rd_addr | input | 4 | Read address |
| rd_data | output | DW | Combinational read data |
| src_pend | input | NCORES*NSRC | Level pending bits, five per core |
| core_irq | output | NCORES | Per-core interrupt request |
| core_pin | output | NCORES*NPINS | Per-core mapped interrupt pins |

## Verification
The assertions assume that `src_pend` and every write input are synchronous to `clk` and stable around its rising edge. They also assume that core numbers stay below NCORES. The clear-all property only constrains cycles with no other-window write, because a same-cycle other write may set bits again after the local clear. The bench changes every input on the falling edge, uses only cores 0 to 3, and samples outputs on the falling edge, at least one full cycle after the write or pending change that affects them.

// File: rtl/lic_pkg.sv
package lic_pkg;
    localparam int NSRC   = 5;
    localparam int ADDR_W = 4;
    localparam int CTL_W  = 5;

    // source bit positions
    localparam int SRC_TMR  = 0;
    localparam int SRC_PERF = 1;
    localparam int SRC_DBG  = 2;
    localparam int SRC_SW0  = 3;
    localparam int SRC_SW1  = 4;

    // control bit positions
    localparam int CTL_TMR_RT  = 0;
    localparam int CTL_PERF_RT = 1;
    localparam int CTL_DBG_RT  = 2;
    localparam int CTL_SW_RT   = 3;
    localparam int CTL_EXT     = 4;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTL  = 4'h0;
    localparam logic [ADDR_W-1:0] A_PEND = 4'h1;
    localparam logic [ADDR_W-1:0] A_MASK = 4'h2;
    localparam logic [ADDR_W-1:0] A_SETM = 4'h3;
    localparam logic [ADDR_W-1:0] A_CLRM = 4'h4;
    localparam logic [ADDR_W-1:0] A_SEL  = 4'h5;
    localparam logic [ADDR_W-1:0] A_MAP0 = 4'h8;

    function automatic logic [NSRC-1:0] routable(input logic [CTL_W-1:0] ctl);
        logic [NSRC-1:0] r;
        r[SRC_TMR]  = ctl[CTL_TMR_RT]  | ctl[CTL_EXT];
        r[SRC_PERF] = ctl[CTL_PERF_RT] | ctl[CTL_EXT];
        r[SRC_DBG]  = ctl[CTL_DBG_RT]  | ctl[CTL_EXT];
        r[SRC_SW0]  = ctl[CTL_SW_RT]   | ctl[CTL_EXT];
        r[SRC_SW1]  = ctl[CTL_SW_RT]   | ctl[CTL_EXT];
        return r;
    endfunction

    function automatic logic is_map(input logic [ADDR_W-1:0] a);
        return (int'(a) >= int'(A_MAP0)) && (int'(a) < int'(A_MAP0) + NSRC);
    endfunction
endpackage

// File: rtl/lic_route.sv
module lic_route
    import lic_pkg::*;
#(
    parameter int NPINS = 6,
    parameter int PIN_W = 3
) (
    input  logic [NSRC-1:0]             pend,
    input  logic [NSRC-1:0]             mask,
    input  logic [CTL_W-1:0]            ctl,
    input  logic [NSRC-1:0]             map_en,
    input  logic [NSRC-1:0][PIN_W-1:0]  map_pin,
    output logic                        irq,
    output logic [NPINS-1:0]            pins
);
    logic [NSRC-1:0] live;

    assign live = pend & mask & routable(ctl);
    assign irq  = |live;

    always_comb begin
        pins = '0;
        for (int s = 0; s < NSRC; s++) begin
            for (int p = 0; p < NPINS; p++) begin
                if (live[s] && map_en[s] && (int'(map_pin[s]) == p)) begin
                    pins[p] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lic_bank.sv
module lic_bank
    import lic_pkg::*;
#(
    parameter int              DW      = 32,
    parameter int              NPINS   = 6,
    parameter int              PIN_W   = 3,
    parameter logic [CTL_W-1:0] CTL_RST = 5'h0F
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC-1:0]             pend,
    input  logic                        lw_en,
    input  logic [ADDR_W-1:0]           lw_addr,
    input  logic [DW-1:0]               lw_data,
    input  logic                        ow_en,
    input  logic [ADDR_W-1:0]           ow_addr,
    input  logic [DW-1:0]               ow_data,
    output logic [CTL_W-1:0]            ctl_o,
    output logic [NSRC-1:0]             mask_o,
    output logic [NSRC-1:0]             map_en_o,
    output logic [NSRC-1:0][PIN_W-1:0]  map_pin_o,
    output logic                        irq_o,
    output logic [NPINS-1:0]            pins_o
);
    typedef struct packed {
        logic [CTL_W-1:0]           ctl;
        logic [NSRC-1:0]            mask;
        logic [NSRC-1:0]            map_en;
        logic [NSRC-1:0][PIN_W-1:0] map_pin;
        logic                       irq;
        logic [NPINS-1:0]           pins;
    } bank_t;

    bank_t            st_d, st_q;
    logic             irq_c;
    logic [NPINS-1:0] pins_c;
    logic             unused_data;

    assign unused_data = ^{lw_data, ow_data};

    function automatic bank_t apply_wr(input bank_t b, input logic [ADDR_W-1:0] a,
                                       input logic [DW-1:0] d);
        bank_t r;
        int    idx;
        r   = b;
        idx = int'(a) - int'(A_MAP0);
        if (a == A_CTL) begin
            r.ctl = d[CTL_W-1:0];
        end else if (a == A_SETM) begin
            r.mask = b.mask | d[NSRC-1:0];
        end else if (a == A_CLRM) begin
            r.mask = b.mask & ~d[NSRC-1:0];
        end else if (is_map(a)) begin
            for (int s = 0; s < NSRC; s++) begin
                if (s == idx) begin
                    r.map_en[s]  = d[DW-1];
                    r.map_pin[s] = d[PIN_W-1:0];
                end
            end
        end
        return r;
    endfunction

    lic_route #(.NPINS(NPINS), .PIN_W(PIN_W)) u_route (
        .pend    (pend),
        .mask    (st_q.mask),
        .ctl     (st_q.ctl),
        .map_en  (st_q.map_en),
        .map_pin (st_q.map_pin),
        .irq     (irq_c),
        .pins    (pins_c)
    );

    always_comb begin
        st_d = st_q;
        if (lw_en) st_d = apply_wr(st_d, lw_addr, lw_data);
        if (ow_en) st_d = apply_wr(st_d, ow_addr, ow_data);
        st_d.irq  = irq_c;
        st_d.pins = pins_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ctl <= CTL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o     = st_q.ctl;
    assign mask_o    = st_q.mask;
    assign map_en_o  = st_q.map_en;
    assign map_pin_o = st_q.map_pin;
    assign irq_o     = st_q.irq;
    assign pins_o    = st_q.pins;
endmodule

// File: rtl/lic_local_unit.sv
module lic_local_unit
    import lic_pkg::*;
#(
    parameter int               NCORES  = 4,
    parameter int               NPINS   = 6,
    parameter int               DW      = 32,
    parameter logic [CTL_W-1:0] CTL_RST = 5'h0F,
    localparam int              CW      = (NCORES > 1) ? $clog2(NCORES) : 1,
    localparam int              PIN_W   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      loc_we,
    input  logic [CW-1:0]             loc_core,
    input  logic [ADDR_W-1:0]         loc_addr,
    input  logic [DW-1:0]             loc_wdata,
    input  logic                      oth_we,
    input  logic [CW-1:0]             oth_core,
    input  logic [ADDR_W-1:0]         oth_addr,
    input  logic [DW-1:0]             oth_wdata,
    input  logic [CW-1:0]             rd_core,
    input  logic                      rd_other,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DW-1:0]             rd_data,
    input  logic [NCORES*NSRC-1:0]    src_pend,
    output logic [NCORES-1:0]         core_irq,
    output logic [NCORES*NPINS-1:0]   core_pin
);
    typedef struct packed {
        logic [NCORES-1:0][CW-1:0] sel;
    } top_t;

    top_t                              top_d, top_q;
    logic [CW-1:0]                     oth_tgt;
    logic [CW-1:0]                     rd_tgt;
    logic [NCORES-1:0][CTL_W-1:0]      ctl_all;
    logic [NCORES-1:0][NSRC-1:0]       mask_all;
    logic [NCORES-1:0][NSRC-1:0]       map_en_all;
    logic [NCORES-1:0][NSRC-1:0][PIN_W-1:0] map_pin_all;
    logic [NCORES*NSRC-1:0]            mask_flat;
    logic [NCORES*CTL_W-1:0]           ctl_flat;
    logic [NCORES*CW-1:0]              sel_flat;

    // selector registers: written only through the local window
    always_comb begin
        top_d = top_q;
        if (loc_we && loc_addr == A_SEL) begin
            top_d.sel[loc_core] = loc_wdata[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign oth_tgt = top_q.sel[oth_core];

    for (genvar c = 0; c < NCORES; c++) begin : g_bank
        lic_bank #(
            .DW(DW), .NPINS(NPINS), .PIN_W(PIN_W), .CTL_RST(CTL_RST)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .pend      (src_pend[c*NSRC +: NSRC]),
            .lw_en     (loc_we && (int'(loc_core) == c)),
            .lw_addr   (loc_addr),
            .lw_data   (loc_wdata),
            .ow_en     (oth_we && (int'(oth_tgt) == c)),
            .ow_addr   (oth_addr),
            .ow_data   (oth_wdata),
            .ctl_o     (ctl_all[c]),
            .mask_o    (mask_all[c]),
            .map_en_o  (map_en_all[c]),
            .map_pin_o (map_pin_all[c]),
            .irq_o     (core_irq[c]),
            .pins_o    (core_pin[c*NPINS +: NPINS])
        );
        assign mask_flat[c*NSRC +: NSRC]   = mask_all[c];
        assign ctl_flat[c*CTL_W +: CTL_W]  = ctl_all[c];
        assign sel_flat[c*CW +: CW]        = top_q.sel[c];
    end

    assign rd_tgt = rd_other ? top_q.sel[rd_core] : rd_core;

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTL) begin
            rd_data[CTL_W-1:0] = ctl_all[rd_tgt];
        end else if (rd_addr == A_PEND) begin
            rd_data[NSRC-1:0] = src_pend[rd_tgt*NSRC +: NSRC];
        end else if (rd_addr == A_MASK) begin
            rd_data[NSRC-1:0] = mask_all[rd_tgt];
        end else if (rd_addr == A_SEL) begin
            if (!rd_other) rd_data[CW-1:0] = top_q.sel[rd_core];
        end else if (is_map(rd_addr)) begin
            for (int s = 0; s < NSRC; s++) begin
                if (int'(rd_addr) - int'(A_MAP0) == s) begin
                    rd_data[DW-1]      = map_en_all[rd_tgt][s];
                    rd_data[PIN_W-1:0] = map_pin_all[rd_tgt][s];
                end
            end
        end
    end
endmodule

// File: rtl/lic_local_unit_chk.sv
module lic_local_unit_chk
    import lic_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NPINS  = 6,
    parameter int CW     = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     loc_we,
    input logic [CW-1:0]            loc_core,
    input logic [ADDR_W-1:0]        loc_addr,
    input logic [NSRC-1:0]          loc_wlow,
    input logic                     oth_we,
    input logic [NCORES*NSRC-1:0]   src_pend,
    input logic [NCORES-1:0]        core_irq,
    input logic [NCORES*NPINS-1:0]  core_pin,
    input logic [NCORES*NSRC-1:0]   mask_flat,
    input logic [NCORES*CTL_W-1:0]  ctl_flat,
    input logic [NCORES*CW-1:0]     sel_flat
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (core_irq == '0 && core_pin == '0));

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        // R3
        idle_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(src_pend[c*NSRC +: NSRC]) == '0) |-> !core_irq[c]);

        // R5
        ext_mode_routes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_flat[c*CTL_W + CTL_EXT] &&
             ((src_pend[c*NSRC +: NSRC] & mask_flat[c*NSRC +: NSRC]) != '0))
            |=> core_irq[c]);

        // R8
        pin_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (core_pin[c*NPINS +: NPINS] != '0) |-> core_irq[c]);

        // R2
        clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (loc_we && int'(loc_core) == c && loc_addr == A_CLRM &&
             (&loc_wlow) && !oth_we) |=> (mask_flat[c*NSRC +: NSRC] == '0));

        // R6
        sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (loc_we && int'(loc_core) == c && loc_addr == A_SEL)
            |=> (sel_flat[c*CW +: CW] == $past(loc_wlow[CW-1:0])));
    end
endmodule

bind lic_local_unit lic_local_unit_chk #(
    .NCORES(NCORES), .NPINS(NPINS), .CW(CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .loc_we    (loc_we),
    .loc_core  (loc_core),
    .loc_addr  (loc_addr),
    .loc_wlow  (loc_wdata[lic_pkg::NSRC-1:0]),
    .oth_we    (oth_we),
    .src_pend  (src_pend),
    .core_irq  (core_irq),
    .core_pin  (core_pin),
    .mask_flat (mask_flat),
    .ctl_flat  (ctl_flat),
    .sel_flat  (sel_flat)
);

// File: tb/lic_local_unit_bench.sv
`timescale 1ns/1ps
module lic_local_unit_bench;
    localparam int NC = 4;
    localparam int NP = 6;
    localparam int DW = 32;
    localparam int NS = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          loc_we = 1'b0;
    logic [1:0]    loc_core = '0;
    logic [3:0]    loc_addr = '0;
    logic [DW-1:0] loc_wdata = '0;
    logic          oth_we = 1'b0;
    logic [1:0]    oth_core = '0;
    logic [3:0]    oth_addr = '0;
    logic [DW-1:0] oth_wdata = '0;
    logic [1:0]    rd_core = '0;
    logic          rd_other = 1'b0;
    logic [3:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [NC*NS-1:0] src_pend = '0;
    logic [NC-1:0]    core_irq;
    logic [NC*NP-1:0] core_pin;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lic_local_unit u_lic_local_unit (
        .clk(clk), .rst_n(rst_n),
        .loc_we(loc_we), .loc_core(loc_core), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .oth_we(oth_we), .oth_core(oth_core), .oth_addr(oth_addr), .oth_wdata(oth_wdata),
        .rd_core(rd_core), .rd_other(rd_other), .rd_addr(rd_addr), .rd_data(rd_data),
        .src_pend(src_pend), .core_irq(core_irq), .core_pin(core_pin)
    );

    // {ctl[4:0], mask[4:0], pend[4:0], expected irq}
    localparam logic [15:0] VEC [11] = '{
        {5'h0F, 5'h1F, 5'h01, 1'b1},
        {5'h0F, 5'h00, 5'h1F, 1'b0},
        {5'h0E, 5'h01, 5'h01, 1'b0},
        {5'h0E, 5'h1F, 5'h01, 1'b0},
        {5'h10, 5'h01, 5'h01, 1'b1},
        {5'h00, 5'h1F, 5'h1F, 1'b0},
        {5'h08, 5'h08, 5'h08, 1'b1},
        {5'h08, 5'h10, 5'h10, 1'b1},
        {5'h07, 5'h18, 5'h18, 1'b0},
        {5'h04, 5'h04, 5'h04, 1'b1},
        {5'h02, 5'h02, 5'h06, 1'b1}
    };

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_loc(input int c, input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        loc_we = 1'b1; loc_core = 2'(c); loc_addr = a; loc_wdata = d;
        @(negedge clk);
        loc_we = 1'b0;
    endtask

    task automatic wr_oth(input int c, input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        oth_we = 1'b1; oth_core = 2'(c); oth_addr = a; oth_wdata = d;
        @(negedge clk);
        oth_we = 1'b0;
    endtask

    task automatic wr_both(input int lc, input logic [3:0] la, input logic [DW-1:0] ld,
                           input int oc, input logic [3:0] oa, input logic [DW-1:0] od);
        @(negedge clk);
        loc_we = 1'b1; loc_core = 2'(lc); loc_addr = la; loc_wdata = ld;
        oth_we = 1'b1; oth_core = 2'(oc); oth_addr = oa; oth_wdata = od;
        @(negedge clk);
        loc_we = 1'b0; oth_we = 1'b0;
    endtask

    task automatic rd(input int c, input bit other, input logic [3:0] a, output logic [DW-1:0] d);
        rd_core = 2'(c); rd_other = other; rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 irq", DW'(core_irq), '0);
        chk("R1 pin", DW'(core_pin), '0);
        rd(0, 0, 4'h0, v); chk("R1 ctl", v, 32'h0F);
        rd(0, 0, 4'h2, v); chk("R1 mask", v, 0);
        rd(0, 0, 4'h5, v); chk("R1 sel", v, 0);
        rd(0, 0, 4'h8, v); chk("R1 map", v, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5: routing table on core 0
        for (int i = 0; i < 11; i++) begin
            string tag;
            wr_loc(0, 4'h0, DW'(VEC[i][15:11]));
            wr_loc(0, 4'h4, 32'hFFFF_FFFF);
            wr_loc(0, 4'h3, DW'(VEC[i][10:6]));
            src_pend[NS-1:0] = VEC[i][5:1];
            settle();
            if (VEC[i][15]) tag = "R5 ext mode";
            else if (VEC[i][0]) tag = "R3 service";
            else tag = "R4 blocked";
            chk(tag, DW'(core_irq[0]), DW'(VEC[i][0]));
            chk("R4 no pin", DW'(core_pin), '0);
            src_pend = '0;
            settle();
        end

        // R2: set and clear mask
        wr_loc(0, 4'h4, 32'hFFFF_FFFF);
        wr_loc(0, 4'h3, 32'h15);
        rd(0, 0, 4'h2, v); chk("R2 set", v, 32'h15);
        wr_loc(0, 4'h3, 32'h02);
        rd(0, 0, 4'h2, v); chk("R2 set or", v, 32'h17);
        wr_loc(0, 4'h4, 32'h05);
        rd(0, 0, 4'h2, v); chk("R2 clear", v, 32'h12);
        wr_loc(0, 4'h4, 32'hFFFF_FFFF);
        rd(0, 0, 4'h2, v); chk("R2 clear all", v, 0);

        // R8: pin mapping
        wr_loc(0, 4'h0, 32'h0F);
        wr_loc(0, 4'h3, 32'h03);
        wr_loc(0, 4'h8, 32'h8000_0005);
        wr_loc(0, 4'h9, 32'h8000_0005);
        src_pend[NS-1:0] = 5'h03;
        settle();
        chk("R8 shared pin", DW'(core_pin[NP-1:0]), 32'h20);
        wr_loc(0, 4'h9, 32'h8000_0002);
        settle();
        chk("R8 two pins", DW'(core_pin[NP-1:0]), 32'h24);
        wr_loc(0, 4'h8, 32'h0000_0005);
        wr_loc(0, 4'h9, 32'h0000_0002);
        settle();
        chk("R8 disabled pin", DW'(core_pin), 0);
        chk("R8 irq stays", DW'(core_irq[0]), 1);
        rd(0, 0, 4'h8, v); chk("R8 map read", v, 32'h5);
        src_pend = '0;
        settle();

        // R6: selector and other window
        wr_loc(1, 4'h5, 32'h2);
        rd(1, 0, 4'h5, v); chk("R6 sel read", v, 2);
        wr_oth(1, 4'h3, 32'h09);
        rd(2, 0, 4'h2, v); chk("R6 target mask", v, 32'h09);
        rd(1, 0, 4'h2, v); chk("R6 own mask", v, 0);
        rd(1, 1, 4'h2, v); chk("R6 other read", v, 32'h09);

        // R9: ignored writes
        wr_oth(1, 4'h5, 32'h3);
        rd(1, 0, 4'h5, v); chk("R9 own sel", v, 2);
        rd(2, 0, 4'h5, v); chk("R9 target sel", v, 0);
        rd(1, 1, 4'h5, v); chk("R9 other sel read", v, 0);
        wr_loc(1, 4'h1, 32'h1F);
        rd(1, 0, 4'h2, v); chk("R9 pend write mask", v, 0);
        settle();
        chk("R9 pend write irq", DW'(core_irq[1]), 0);

        // R7: same-cycle ordering, local then other
        wr_loc(2, 4'h5, 32'h3);
        wr_both(3, 4'h3, 32'h1F, 2, 4'h4, 32'h01);
        rd(3, 0, 4'h2, v); chk("R7 mask order", v, 32'h1E);
        wr_both(3, 4'hA, 32'h8000_0001, 2, 4'hA, 32'h8000_0004);
        rd(3, 0, 4'hA, v); chk("R7 map order", v, 32'h8000_0004);

        // R1: reset again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rd(2, 0, 4'h2, v); chk("R1 mask after reset", v, 0);
        rd(1, 0, 4'h5, v); chk("R1 sel after reset", v, 0);
        rd(3, 0, 4'hA, v); chk("R1 map after reset", v, 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule